// File: doc/BRIEF.md
# Processor Status Flag Register with Indexed Bit Operations

This block holds the eight condition and control flags of a small processor core. One indexed path serves every flag: a 3-bit index chooses the bit, and the operation code says whether to force it to 1 or to 0. The block also moves single bits between the status byte and a general register through a transfer flag (T). A bit-store copies one chosen bit of a register operand into T. A bit-load returns the register operand with one chosen bit replaced by T.

Alongside these explicit operations, an arithmetic unit can update any subset of flags through a masked write port in the same cycle. Where both touch the same bit, the explicit operation takes precedence, and the masked update still lands on the other bits. Every operation finishes within a single cycle. The status byte updates at the next clock edge. The bit-load result is combinational in the cycle of the request.

Top module: `status_bitops`

## Requirements
- R1: Synchronous active-high reset forces the status byte to 0x00.
- R2: Operation code 1 (flag-set) writes 1 to the status bit picked by `bit_sel_i`, visible after the next clock edge.
- R3: Operation code 2 (flag-clear) writes 0 to the status bit picked by `bit_sel_i`, visible after the next clock edge.
- R4: The index chooses status bits as 0=C, 1=Z, 2=N, 3=V, 4=S, 5=H, 6=T, 7=I. Each named flag set or clear is flag-set or flag-clear with that index.
- R5: Operation code 3 (bit-store) copies bit `bit_sel_i` of `reg_in_i` into T (status bit 6). Through explicit operations it alters no other status bit.
- R6: Operation code 4 (bit-load) drives `reg_out_o` in the same cycle as `reg_in_i`, with bit `bit_sel_i` replaced by the current T. The explicit path leaves the status byte unchanged.
- R7: For every bit whose `alu_we_i` mask bit is 1 and which no explicit operation targets, the status bit takes `alu_flags_i` after the next clock edge.
- R8: When an explicit operation and the masked update target the same bit in one cycle, the explicit operation's value is stored.
- R9: Operation code 0 and the unused codes 5 to 7 change no status bit without a masked update. With any code other than 4, `reg_out_o` equals `reg_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 none, 1 set, 2 clear, 3 bit-store, 4 bit-load |
| bit_sel_i | input | 3 | Bit index for the operation |
| reg_in_i | input | 8 | General register operand |
| alu_we_i | input | 8 | Per-bit write mask from the arithmetic unit |
| alu_flags_i | input | 8 | Flag values from the arithmetic unit |
| status_o | output | 8 | Current status byte (I,T,H,S,V,N,Z,C from bit 7 down) |
| reg_out_o | output | 8 | Register byte after bit-load |

## Verification
`reg_out_o` is due in the same cycle as the request, so the bench reads it a short settle time after driving the inputs at the falling edge. Status effects of set, clear, bit-store and masked updates are due one rising edge later, so the bench compares `status_o` with its model at the next falling edge. A behavioural model in the bench is updated once per step, and both outputs are compared against it on every cycle. Directed steps cover each index and each conflict case, and a seeded random phase mixes all the operation codes.

// File: rtl/status_bitops_pkg.sv
package status_bitops_pkg;

    localparam int FLAG_W  = 8;
    localparam int IDX_W   = $clog2(FLAG_W);

    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_N = 2;
    localparam int POS_V = 3;
    localparam int POS_S = 4;
    localparam int POS_H = 5;
    localparam int POS_T = 6;
    localparam int POS_I = 7;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_FSET   = 3'd1,
        OP_FCLR   = 3'd2,
        OP_TSTORE = 3'd3,
        OP_TLOAD  = 3'd4
    } bitop_e;

    typedef struct packed {
        logic [FLAG_W-1:0] set_mask;
        logic [FLAG_W-1:0] clr_mask;
        logic              t_we;
        logic              t_val;
    } explicit_req_t;

    function automatic logic [FLAG_W-1:0] idx_to_mask(input logic [IDX_W-1:0] idx);
        logic [FLAG_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/status_bitops_decode.sv
module status_bitops_decode
    import status_bitops_pkg::*;
(
    input  logic [2:0]        op_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    input  logic [FLAG_W-1:0] reg_in_i,
    output explicit_req_t     req_o
);
    logic [FLAG_W-1:0] sel_mask;

    always_comb begin
        sel_mask = idx_to_mask(bit_sel_i);
        req_o    = '0;
        case (op_i)
            OP_FSET:   req_o.set_mask = sel_mask;
            OP_FCLR:   req_o.clr_mask = sel_mask;
            OP_TSTORE: begin
                req_o.t_we  = 1'b1;
                req_o.t_val = reg_in_i[bit_sel_i];
            end
            default:   req_o = '0;
        endcase
    end
endmodule

// File: rtl/status_bitops_regbits.sv
module status_bitops_regbits
    import status_bitops_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    input  logic [FLAG_W-1:0] reg_in_i,
    input  logic              t_flag_i,
    output logic [FLAG_W-1:0] reg_out_o
);
    always_comb begin
        reg_out_o = reg_in_i;
        if (op_i == OP_TLOAD)
            reg_out_o[bit_sel_i] = t_flag_i;
    end

    // R6: bit-load puts T at the chosen position and keeps every other bit
    p_load_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_TLOAD) |->
            (reg_out_o[bit_sel_i] == t_flag_i) &&
            (((reg_out_o ^ reg_in_i) & ~idx_to_mask(bit_sel_i)) == '0));

    // R9: any other code passes the operand through untouched
    p_passthru_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_TLOAD) |-> (reg_out_o == reg_in_i));
endmodule

// File: rtl/status_bitops_store.sv
module status_bitops_store
    import status_bitops_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  explicit_req_t     req_i,
    input  logic [FLAG_W-1:0] alu_we_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    output logic [FLAG_W-1:0] status_o
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;
    logic [FLAG_W-1:0] explicit_hit;

    for (genvar k = 0; k < FLAG_W; k++) begin : g_bit
        logic t_hit;
        if (k == POS_T) begin : g_tbit
            assign t_hit = req_i.t_we;
        end else begin : g_plain
            assign t_hit = 1'b0;
        end

        assign explicit_hit[k] = req_i.set_mask[k] | req_i.clr_mask[k] | t_hit;

        always_comb begin
            if (req_i.set_mask[k])      flags_d[k] = 1'b1;
            else if (req_i.clr_mask[k]) flags_d[k] = 1'b0;
            else if (t_hit)             flags_d[k] = req_i.t_val;
            else if (alu_we_i[k])       flags_d[k] = alu_flags_i[k];
            else                        flags_d[k] = flags_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign status_o = flags_q;

    // R7: unclaimed masked bits follow the arithmetic unit
    p_alu_write_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(alu_we_i) & ~$past(explicit_hit)) &
                   (flags_q ^ $past(alu_flags_i))) == '0));

    // R9: bits no request touches keep their value
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((~$past(alu_we_i) & ~$past(explicit_hit)) &
                   (flags_q ^ $past(flags_q))) == '0));
endmodule

// File: rtl/status_bitops.sv
module status_bitops
    import status_bitops_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] op_i,
    input  logic [2:0] bit_sel_i,
    input  logic [7:0] reg_in_i,
    input  logic [7:0] alu_we_i,
    input  logic [7:0] alu_flags_i,
    output logic [7:0] status_o,
    output logic [7:0] reg_out_o
);
    explicit_req_t req;

    status_bitops_decode u_decode (
        .op_i      (op_i),
        .bit_sel_i (bit_sel_i),
        .reg_in_i  (reg_in_i),
        .req_o     (req)
    );

    status_bitops_store u_store (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .alu_we_i    (alu_we_i),
        .alu_flags_i (alu_flags_i),
        .status_o    (status_o)
    );

    status_bitops_regbits u_regbits (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .bit_sel_i (bit_sel_i),
        .reg_in_i  (reg_in_i),
        .t_flag_i  (status_o[POS_T]),
        .reg_out_o (reg_out_o)
    );

    // R2, R8: a set request wins over everything at its bit
    p_set_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_FSET) |=> status_o[$past(bit_sel_i)] == 1'b1);

    // R3, R8: a clear request wins over everything at its bit
    p_clear_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_FCLR) |=> status_o[$past(bit_sel_i)] == 1'b0);

    // R5: bit-store lands the operand bit in T
    p_tstore_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_TSTORE) |=> status_o[POS_T] == $past(reg_in_i[bit_sel_i]));
endmodule

// File: tb/status_bitops_test.sv
`timescale 1ns/1ps
module status_bitops_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = '0;
    logic [2:0] bit_sel_i = '0;
    logic [7:0] reg_in_i = '0;
    logic [7:0] alu_we_i = '0;
    logic [7:0] alu_flags_i = '0;
    logic [7:0] status_o;
    logic [7:0] reg_out_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = 8'h00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    status_bitops uut (
        .clk(clk), .rst(rst), .op_i(op_i), .bit_sel_i(bit_sel_i),
        .reg_in_i(reg_in_i), .alu_we_i(alu_we_i), .alu_flags_i(alu_flags_i),
        .status_o(status_o), .reg_out_o(reg_out_o)
    );

    task automatic check8(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus; output compared in-cycle, status after the edge
    task automatic step(input string tag, input logic [2:0] op, input logic [2:0] sel,
                        input logic [7:0] rin, input logic [7:0] we, input logic [7:0] fl);
        logic [7:0] exp_out;
        logic [7:0] nxt;
        @(negedge clk);
        op_i = op; bit_sel_i = sel; reg_in_i = rin; alu_we_i = we; alu_flags_i = fl;
        #1;
        exp_out = rin;
        if (op == 3'd4) exp_out[sel] = model[6];
        check8(tag, "reg_out", reg_out_o, exp_out);
        nxt = (model & ~we) | (fl & we);
        case (op)
            3'd1: nxt[sel] = 1'b1;
            3'd2: nxt[sel] = 1'b0;
            3'd3: nxt[6] = rin[sel];
            default: ;
        endcase
        model = nxt;
        @(negedge clk);
        check8(tag, "status", status_o, model);
        op_i = 3'd0; alu_we_i = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check8("R1", "reset", status_o, 8'h00);

        // R2 R4: set every flag by index, then R3 clear each
        for (int i = 0; i < 8; i++) step("R2", 3'd1, i[2:0], 8'h00, 8'h00, 8'h00);
        step("R4", 3'd2, 3'd0, 8'h00, 8'h00, 8'h00);
        check8("R4", "C cleared is bit0", status_o, 8'hFE);
        for (int i = 1; i < 8; i++) step("R3", 3'd2, i[2:0], 8'h00, 8'h00, 8'h00);
        // R4: set I (7) alone
        step("R4", 3'd1, 3'd7, 8'h00, 8'h00, 8'h00);
        check8("R4", "I is bit7", status_o, 8'h80);
        // R5: bit-store both values
        step("R5", 3'd3, 3'd5, 8'h20, 8'h00, 8'h00);
        step("R5", 3'd3, 3'd2, 8'hFB, 8'h00, 8'h00);
        step("R5", 3'd3, 3'd0, 8'h01, 8'h00, 8'h00);
        // R6: bit-load with T=1 and T=0
        step("R6", 3'd4, 3'd3, 8'h00, 8'h00, 8'h00);
        step("R5", 3'd3, 3'd1, 8'h00, 8'h00, 8'h00);
        step("R6", 3'd4, 3'd7, 8'hFF, 8'h00, 8'h00);
        // R7: masked updates
        step("R7", 3'd0, 3'd0, 8'h00, 8'h0F, 8'h05);
        step("R7", 3'd0, 3'd0, 8'h00, 8'hF0, 8'hA0);
        // R8: conflicts
        step("R8", 3'd1, 3'd2, 8'h00, 8'hFF, 8'h00);
        step("R8", 3'd2, 3'd7, 8'h00, 8'hFF, 8'hFF);
        step("R8", 3'd3, 3'd4, 8'h00, 8'h40, 8'h40);
        // R9: unused codes
        step("R9", 3'd5, 3'd1, 8'h3C, 8'h00, 8'hFF);
        step("R9", 3'd7, 3'd6, 8'hC3, 8'h00, 8'h00);
        step("R9", 3'd0, 3'd3, 8'h5A, 8'h00, 8'hFF);

        // mixed random phase
        for (int i = 0; i < 400; i++)
            step("R7 R8 random", 3'($urandom_range(0, 7)), 3'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom));

        // R1: reset from a nonzero state
        step("R1", 3'd0, 3'd0, 8'h00, 8'hFF, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; model = 8'h00;
        check8("R1", "mid-run reset", status_o, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule